// File: doc/BRIEF.md
# General-Purpose Port Data Register

This block holds the output data of a 16-pin general-purpose I/O port and works out what each pin drives and what a bus read returns. A per-pin direction vector, supplied from a separate control register, selects for every bit whether the pin is a driven output or a sampled input. Output pins drive the stored bit. Input pins are sampled through a two-stage synchronizer, and a read returns the synchronized pin level in place of the stored bit.

An active-low output-disable pin can float the five lowest pins at once, for example on an emergency stop. The upper eleven pins ignore it. The stored value survives a reset raised by the watchdog. It is cleared by an external power-on reset and by hardware standby. Writes are a single-cycle strobe with one enable per byte. The write path has no back-pressure: there is no ready signal, every strobe is taken in the cycle it is presented, and the read data is a plain combinational output.

Top module: `gpio_dr_port`

## Requirements
- R1: While `rst_n` is low with `rst_is_wdt` = 0 (external power-on reset), each rising clock edge clears the stored value to 0x0000, so `pin_out` reads 0x0000 once reset is released.
- R2: For a bit with `dir` = 1 (output), `rd_data` returns the stored bit whatever level is on `pin_in`. `pin_out` carries the stored bit, and `pin_oe` is 1 unless R6 applies.
- R3: For a bit with `dir` = 0 (input), `pin_oe` is 0 and `rd_data` returns the `pin_in` level captured two rising edges earlier. A level set before edge k is first seen after edge k+1.
- R4: A write to a bit whose `dir` is 0 still updates the stored bit. The change shows on `pin_out`, but `pin_oe` stays 0.
- R5: A write with `wr_stb` = 1 updates bits 7:0 only when `wr_be[0]` = 1 and bits 15:8 only when `wr_be[1]` = 1. The new value appears after the same rising edge.
- R6: While `pod_n` = 0, `pin_oe[4:0]` is 0 whatever `dir` and the stored value hold. With `pod_n` = 1, those pins follow R2 and R3.
- R7: `pin_oe[15:5]` equals `dir[15:5]` at all times. `pod_n` has no effect on these pins.
- R8: While `hw_stby` = 1, each rising edge clears the stored value to 0x0000, and writes are not taken.
- R9: While `rst_n` is low with `rst_is_wdt` = 1 (watchdog reset), the stored value is kept. Writes are ignored during any reset.
- R10: When a `dir` bit changes from 0 to 1, `rd_data`, `pin_oe` and the pin drive take the stored bit in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, held for at least one rising edge |
| rst_is_wdt | input | 1 | Cause of the current reset: 1 = watchdog, 0 = external power-on |
| hw_stby | input | 1 | Hardware standby, active high; clears the stored value |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data: stored bit on output pins, synchronized pin level on input pins |
| dir | input | 16 | Per-pin direction: 1 = output, 0 = input |
| pod_n | input | 1 | Active-low output disable for pins 4:0 |
| pin_in | input | 16 | Pin levels seen at the pads |
| pin_out | output | 16 | Value driven to the pads |
| pin_oe | output | 16 | Per-pin pad output enable |

## Verification
The assertions take for granted that `rst_n` is held low for at least one rising edge, so that the synchronizer and the stored value start from a known state. They also assume that `rst_is_wdt` stays stable while reset is low. The input-path check counts cycles since reset and waits until both synchronizer stages hold sampled pin levels. The stimulus changes every input just after a falling edge, holds each table row for two rising edges so that pin changes have passed the synchronizer, and always enters reset with a defined cause.

// File: rtl/gpio_dr_pkg.sv
package gpio_dr_pkg;
  localparam int unsigned PORT_W    = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned DIS_PINS  = 5;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    CLR_NONE  = 2'b00,
    CLR_POR   = 2'b01,
    CLR_STBY  = 2'b10
  } clr_cause_e;

  function automatic int unsigned lanes(input int unsigned width);
    return (width + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/gpio_dr_sync.sv
module gpio_dr_sync #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[DEPTH-1];
endmodule

// File: rtl/gpio_dr_store.sv
module gpio_dr_store
  import gpio_dr_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned NLANE = lanes(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_is_wdt,
  input  logic             hw_stby,
  input  logic             wr_stb,
  input  logic [NLANE-1:0] wr_be,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] data_q
);
  clr_cause_e clr_cause;
  logic       take_write;

  always_comb begin
    if (hw_stby)                   clr_cause = CLR_STBY;
    else if (!rst_n && !rst_is_wdt) clr_cause = CLR_POR;
    else                           clr_cause = CLR_NONE;
  end

  assign take_write = wr_stb && rst_n && (clr_cause == CLR_NONE);

  generate
    for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
      localparam int unsigned LO = ln * BYTE_W;
      localparam int unsigned HI = ((ln + 1) * BYTE_W > WIDTH) ? WIDTH - 1 : (ln + 1) * BYTE_W - 1;
      always_ff @(posedge clk) begin
        if (clr_cause != CLR_NONE)         data_q[HI:LO] <= '0;
        else if (take_write && wr_be[ln])  data_q[HI:LO] <= wr_data[HI:LO];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_dr_drive.sv
module gpio_dr_drive #(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned DIS_PINS = 5
) (
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir,
  input  logic             pod_n,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  assign pin_out = data_q;

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
      if (b < DIS_PINS) begin : g_gated
        assign pin_oe[b] = dir[b] & pod_n;
      end else begin : g_free
        assign pin_oe[b] = dir[b];
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_dr_rdmux.sv
module gpio_dr_rdmux #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] dir,
  output logic [WIDTH-1:0] rd_data
);
  always_comb begin
    for (int b = 0; b < WIDTH; b++) begin
      rd_data[b] = dir[b] ? data_q[b] : pin_sync[b];
    end
  end
endmodule

// File: rtl/gpio_dr_port.sv
module gpio_dr_port
  import gpio_dr_pkg::*;
#(
  parameter int unsigned WIDTH    = PORT_W,
  parameter int unsigned DIS_PINS = gpio_dr_pkg::DIS_PINS,
  parameter int unsigned SYNC_N   = SYNC_DEPTH,
  localparam int unsigned NLANE   = lanes(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_is_wdt,
  input  logic             hw_stby,
  input  logic             wr_stb,
  input  logic [NLANE-1:0] wr_be,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] dir,
  input  logic             pod_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] pin_sync;

  gpio_dr_store #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .rst_is_wdt(rst_is_wdt), .hw_stby(hw_stby),
    .wr_stb(wr_stb), .wr_be(wr_be), .wr_data(wr_data), .data_q(data_q)
  );

  gpio_dr_sync #(.WIDTH(WIDTH), .DEPTH(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_dr_drive #(.WIDTH(WIDTH), .DIS_PINS(DIS_PINS)) u_drive (
    .data_q(data_q), .dir(dir), .pod_n(pod_n), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  gpio_dr_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .data_q(data_q), .pin_sync(pin_sync), .dir(dir), .rd_data(rd_data)
  );
endmodule

// File: rtl/gpio_dr_port_chk.sv
module gpio_dr_port_chk #(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned DIS_PINS = 5,
  parameter int unsigned NLANE    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_is_wdt,
  input logic             hw_stby,
  input logic             wr_stb,
  input logic [NLANE-1:0] wr_be,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] dir,
  input logic             pod_n,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe
);
  logic [1:0] warm_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end

  a_r1_por_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n && !rst_is_wdt) |-> (pin_out == '0));

  a_r2_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data ^ pin_out) & dir) == '0);

  a_r3_in_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt >= 2'd2) |-> (((rd_data ^ $past(pin_in, 2)) & ~dir) == '0));

  a_r3_in_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir) == '0);

  a_r5_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_be == '1) && !hw_stby) |=> (pin_out == $past(wr_data)));

  a_r5_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_stby && !(wr_stb && wr_be[1])) |=> (pin_out[WIDTH-1:8] == $past(pin_out[WIDTH-1:8])));

  a_r6_pod_float: assert property (@(posedge clk) disable iff (!rst_n)
    !pod_n |-> (pin_oe[DIS_PINS-1:0] == '0));

  a_r7_upper_free: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[WIDTH-1:DIS_PINS] == dir[WIDTH-1:DIS_PINS]);

  a_r8_stby_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hw_stby) |-> (pin_out == '0));
endmodule

bind gpio_dr_port gpio_dr_port_chk #(.WIDTH(WIDTH), .DIS_PINS(DIS_PINS), .NLANE(NLANE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_is_wdt(rst_is_wdt), .hw_stby(hw_stby),
  .wr_stb(wr_stb), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
  .dir(dir), .pod_n(pod_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_dr_port_bench.sv
module gpio_dr_port_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] dir;
    logic        pod_n;
    logic [15:0] pin;
    logic        wr;
    logic [1:0]  be;
    logic [15:0] wdata;
    logic [15:0] exp_rd;
    logic [15:0] exp_oe;
    logic [15:0] exp_out;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{16'hFFFF, 1'b1, 16'h0000, 1'b1, 2'b11, 16'hA5C3, 16'hA5C3, 16'hFFFF, 16'hA5C3},
    '{16'hFFFF, 1'b0, 16'h1234, 1'b0, 2'b00, 16'h0000, 16'hA5C3, 16'hFFE0, 16'hA5C3},
    '{16'h0000, 1'b1, 16'h1234, 1'b1, 2'b01, 16'hFFFF, 16'h1234, 16'h0000, 16'hA5FF},
    '{16'hFF00, 1'b1, 16'hBEEF, 1'b1, 2'b10, 16'h3C00, 16'h3CEF, 16'hFF00, 16'h3CFF},
    '{16'h00FF, 1'b0, 16'h5A5A, 1'b0, 2'b00, 16'h0000, 16'h5AFF, 16'h00E0, 16'h3CFF},
    '{16'h001F, 1'b0, 16'hFFFF, 1'b1, 2'b11, 16'h0000, 16'hFFE0, 16'h0000, 16'h0000},
    '{16'h001F, 1'b1, 16'h0000, 1'b1, 2'b00, 16'hFFFF, 16'h0000, 16'h001F, 16'h0000},
    '{16'hF0F0, 1'b1, 16'h0F0F, 1'b1, 2'b11, 16'h1357, 16'h1F5F, 16'hF0F0, 16'h1357}
  };

  logic        clk = 1'b0;
  logic        rst_n, rst_is_wdt, hw_stby, wr_stb, pod_n;
  logic [1:0]  wr_be;
  logic [15:0] wr_data, dir, pin_in;
  logic [15:0] rd_data, pin_out, pin_oe;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_dr_port u_gpio_dr_port (
    .clk(clk), .rst_n(rst_n), .rst_is_wdt(rst_is_wdt), .hw_stby(hw_stby),
    .wr_stb(wr_stb), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
    .dir(dir), .pod_n(pod_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic next_neg();
    @(negedge clk);
  endtask

  task automatic write_word(input logic [1:0] be, input logic [15:0] d);
    wr_stb = 1'b1; wr_be = be; wr_data = d;
    next_neg();
    wr_stb = 1'b0; wr_be = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rst_is_wdt = 1'b0; hw_stby = 1'b0; wr_stb = 1'b0;
    wr_be = 2'b00; wr_data = 16'h0; dir = 16'hFFFF; pod_n = 1'b1; pin_in = 16'h0;
    next_neg(); next_neg();
    rst_n = 1'b1;
    #1;
    check("R1", "reset pin_out", pin_out, 16'h0000);
    check("R1", "reset rd_data", rd_data, 16'h0000);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NROWS; i++) begin
      dir = ROWS[i].dir; pod_n = ROWS[i].pod_n; pin_in = ROWS[i].pin;
      wr_stb = ROWS[i].wr; wr_be = ROWS[i].be; wr_data = ROWS[i].wdata;
      next_neg();
      wr_stb = 1'b0; wr_be = 2'b00;
      next_neg();
      #1;
      check("R2/R3", $sformatf("row %0d rd_data", i), rd_data, ROWS[i].exp_rd);
      check("R6/R7", $sformatf("row %0d pin_oe", i), pin_oe, ROWS[i].exp_oe);
      check("R4/R5", $sformatf("row %0d pin_out", i), pin_out, ROWS[i].exp_out);
    end

    // R3: input sync latency
    dir = 16'h0000; pod_n = 1'b1; pin_in = 16'h0000;
    next_neg(); next_neg();
    pin_in = 16'h8001;
    next_neg(); #1;
    check("R3", "one edge after change", rd_data, 16'h0000);
    next_neg(); #1;
    check("R3", "two edges after change", rd_data, 16'h8001);

    // R4: write to input pins, no drive
    write_word(2'b11, 16'h00F0); #1;
    check("R4", "input write pin_out", pin_out, 16'h00F0);
    check("R4", "input write pin_oe", pin_oe, 16'h0000);
    check("R4", "input write rd_data", rd_data, 16'h8001);

    // R10: direction flip shows stored value without a clock
    dir = 16'hFFFF; #1;
    check("R10", "flip rd_data", rd_data, 16'h00F0);
    check("R10", "flip pin_oe", pin_oe, 16'hFFFF);

    // R6 combinational disable
    pod_n = 1'b0; #1;
    check("R6", "pod low oe", pin_oe, 16'hFFE0);
    pod_n = 1'b1;

    // R8: hardware standby clears and blocks writes
    write_word(2'b11, 16'h7E7E);
    hw_stby = 1'b1;
    write_word(2'b11, 16'h1111); #1;
    check("R8", "standby clear", pin_out, 16'h0000);
    hw_stby = 1'b0;
    next_neg(); #1;
    check("R8", "write during standby dropped", pin_out, 16'h0000);

    // R9: watchdog reset keeps value, writes ignored
    write_word(2'b11, 16'hCAFE);
    rst_is_wdt = 1'b1; rst_n = 1'b0;
    write_word(2'b11, 16'h0BAD);
    next_neg();
    rst_n = 1'b1; #1;
    check("R9", "wdt reset keeps value", pin_out, 16'hCAFE);
    rst_is_wdt = 1'b0;
    next_neg(); #1;
    check("R9", "after wdt reset rd", rd_data, 16'hCAFE);

    // R1: external reset clears a written value
    rst_n = 1'b0;
    next_neg();
    rst_n = 1'b1; #1;
    check("R1", "external reset clears", pin_out, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule